// File: doc/BRIEF.md
# Keyed Watchdog Timer with Time-Base

This block supervises software by raising a reset request when the program stops proving that it is alive. A free-running binary divider acts as the time-base. One of its upper bits is chosen as the watchdog tick. Each falling edge of that tick arms a detection flag. If a second falling edge finds the flag still set, a reset pulse of fixed length is issued. Software restarts the watchdog through a key register. It writes 0xA5 and then 0x5A, and that pair wipes the flag.

A small control register holds three fields: the tick selection, a half-rate mode that advances the divider only on every second clock, and a sticky enable. While the enable is clear, the watchdog never requests a reset. Once the enable is set, the tick selection and the rate mode are frozen until the next system reset. Four hold-off inputs cover these conditions: low-power state, DMA activity, debug halt, and trap or single-step entry. While any of them is high, the flag is kept clear, so no reset can be requested.

Top module: `wdt_keyed`

## Requirements
- R1: After system reset, `rst_req` is low, `tap_sel` reads 0, the watchdog is disabled and the divider restarts from zero.
- R2: The divider advances by one on every clock. When the half-rate bit (control bit 2) is set, it advances only on every second clock. The watchdog tick is divider bit `TAP_BASE + tap_sel`.
- R3: A write to address 0 sets the enable when bit 7 is 1. The enable stays set until system reset. The same write loads bits [1:0] into the tick selection and bit 2 into the half-rate mode, but only while the enable was still clear before the write.
- R4: While the enable is clear, `rst_req` stays low.
- R5: While enabled, a falling tick edge sets a clear flag. A falling tick edge that finds the flag set instead starts a reset request. `rst_req` goes high on the following cycle and stays high for `PULSE_LEN` cycles.
- R6: A write of 0xA5 to address 1 arms the key. A write of 0x5A to address 1 while the key is armed clears the flag and disarms the key. Any other value written to address 1 disarms the key. A 0x5A write without a preceding armed 0xA5 has no effect.
- R7: Any number of cycles may pass between the 0xA5 and the 0x5A of a key pair.
- R8: A completing 0x5A written in the same cycle as a falling tick edge leaves the flag clear, and no reset request follows from that edge.
- R9: While any `holdoff` bit is 1, the flag is held clear, and a falling tick edge in that cycle neither sets the flag nor starts a reset request.
- R10: `tap_sel` always shows the stored tick selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects key |
| wr_data | input | 8 | Write data |
| holdoff | input | HO_N | Reset-deferral conditions: low-power, DMA, debug halt, trap |
| rst_req | output | 1 | Reset request pulse |
| tap_sel | output | SEL_W | Stored tick selection |

## Verification
Two pairs of events can land in the same cycle: a completing 0x5A write against a falling tick edge that finds the flag set, and a hold-off input against such an edge. The bench tracks the behavioural model's divider to find a cycle in which a falling edge is due with the flag set. It issues the 0x5A write exactly on that edge. It then confirms that no reset pulse appears during the following tick period, where an unserviced edge would have produced one at once. The hold-off case is driven by holding each input high across many tick periods. Every cycle, the model's `rst_req` and `tap_sel` are compared with the design's outputs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_KEY  = 1'b1;
  localparam logic [KEY_W-1:0] KEY_ARM  = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_DONE = 8'h5A;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_HALF_BIT = 2;
  typedef enum int {HO_LOWPWR = 0, HO_DMA = 1, HO_DEBUG = 2, HO_TRAP = 3} holdoff_e;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int TAP_BASE = 17,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_rate,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_fall
);
  localparam int NTAP  = 1 << SEL_W;
  localparam int DIV_W = TAP_BASE + NTAP;

  logic [DIV_W-1:0] div_q, div_d;
  logic             ph_q, ph_d;
  logic             prev_q;
  logic             step;
  logic [NTAP-1:0]  taps;
  logic             tap_now;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign taps[g] = div_q[TAP_BASE+g];
  end

  always_comb begin
    step     = !half_rate || ph_q;
    div_d    = step ? div_q + 1'b1 : div_q;
    ph_d     = half_rate ? !ph_q : 1'b0;
    tap_now  = taps[sel];
    tap_fall = prev_q && !tap_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ph_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      ph_q   <= ph_d;
      prev_q <= tap_now;
    end
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_key,
  input  logic [KEY_W-1:0] data,
  output logic             key_clr
);
  logic armed_q, armed_d;

  always_comb begin
    key_clr = wr_key && armed_q && (data == KEY_DONE);
    armed_d = wr_key ? (data == KEY_ARM) : armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (fire)              cnt_d = LEN;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
    req = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int TAP_BASE  = 17,
  parameter int SEL_W     = 2,
  parameter int PULSE_LEN = 16,
  parameter int HO_N      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  input  logic [HO_N-1:0]  holdoff,
  output logic             rst_req,
  output logic [SEL_W-1:0] tap_sel
);
  logic             sync1_q, rst_n_s;
  logic             act_q, act_d;
  logic             half_q, half_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             flag_q, flag_d;
  logic             wr_ctrl, wr_key, key_clr, tap_fall, hold_any, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_n_s <= sync1_q;
    end
  end

  wdt_timebase #(.TAP_BASE(TAP_BASE), .SEL_W(SEL_W)) u_tb (
    .clk(clk), .rst_n(rst_n_s), .half_rate(half_q), .sel(sel_q), .tap_fall(tap_fall)
  );

  wdt_keyseq u_key (
    .clk(clk), .rst_n(rst_n_s), .wr_key(wr_key), .data(wr_data), .key_clr(key_clr)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n_s), .fire(fire), .req(rst_req)
  );

  always_comb begin
    wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    wr_key   = wr_en && (wr_addr == ADDR_KEY);
    hold_any = |holdoff;
    act_d    = act_q || (wr_ctrl && wr_data[CTRL_EN_BIT]);
    sel_d    = sel_q;
    half_d   = half_q;
    if (wr_ctrl && !act_q) begin
      sel_d  = wr_data[SEL_W-1:0];
      half_d = wr_data[CTRL_HALF_BIT];
    end
    fire   = 1'b0;
    flag_d = flag_q;
    if (!act_q || hold_any || key_clr) begin
      flag_d = 1'b0;
    end else if (tap_fall) begin
      fire   = flag_q;
      flag_d = !flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      sel_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      half_q <= half_d;
      sel_q  <= sel_d;
      flag_q <= flag_d;
    end
  end

  assign tap_sel = sel_q;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             flag,
  input logic             tap_fall,
  input logic             hold_any,
  input logic             key_clr,
  input logic             rst_req,
  input logic [SEL_W-1:0] tap_sel
);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !rst_req);
  // R3
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active && $stable(tap_sel));
  // R8
  key_wipes_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr |=> !flag);
  // R9
  holdoff_wipes_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_any |=> !flag);
  // R5
  second_edge_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(flag) && $past(tap_fall) && !$past(hold_any) && !$past(key_clr));
endmodule

bind wdt_keyed wdt_keyed_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .active(act_q), .flag(flag_q), .tap_fall(tap_fall),
  .hold_any(hold_any), .key_clr(key_clr), .rst_req(rst_req), .tap_sel(tap_sel)
);

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
  localparam int TB = 2;
  localparam int PL = 4;
  localparam int WRAP = 1 << (TB + 4);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] holdoff = 4'h0;
  logic       rst_req;
  logic [1:0] tap_sel;

  int checks = 0, fails = 0, pulses = 0, cyc = 0;
  string cur_req = "R1";
  logic prev_req = 1'b0;

  int m_sync, m_cnt, m_ph, m_prev, m_sel, m_half, m_act, m_armed, m_flag, m_pulse;

  wdt_keyed #(.TAP_BASE(TB), .SEL_W(2), .PULSE_LEN(PL), .HO_N(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .holdoff(holdoff), .rst_req(rst_req), .tap_sel(tap_sel)
  );

  always #4 clk = !clk;

  function automatic int tapbit(int cnt, int sel);
    return (cnt >> (TB + sel)) & 1;
  endfunction

  task automatic model_step();
    int cur, fall, clr, hold, nf, fire;
    cur  = tapbit(m_cnt, m_sel);
    fall = m_prev && !cur;
    clr  = wr_en && wr_addr == 1'b1 && wr_data == 8'h5A && m_armed;
    hold = (holdoff != 0);
    fire = 0;
    if (!m_act || hold || clr) nf = 0;
    else if (fall) begin
      if (m_flag) begin fire = 1; nf = 0; end
      else nf = 1;
    end else nf = m_flag;
    if (fire) m_pulse = PL;
    else if (m_pulse > 0) m_pulse--;
    m_prev = cur;
    if (!m_half || m_ph) m_cnt = (m_cnt + 1) % WRAP;
    m_ph = m_half ? !m_ph : 0;
    if (wr_en && wr_addr == 1'b1) m_armed = (wr_data == 8'hA5);
    if (wr_en && wr_addr == 1'b0) begin
      if (!m_act) begin m_sel = wr_data[1:0]; m_half = wr_data[2]; end
      if (wr_data[7]) m_act = 1;
    end
    m_flag = nf;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_cnt = 0; m_ph = 0; m_prev = 0; m_sel = 0; m_half = 0;
      m_act = 0; m_armed = 0; m_flag = 0; m_pulse = 0;
    end else begin
      if (m_sync >= 2) model_step();
      if (m_sync < 2) m_sync++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rst_req == (m_pulse != 0), cur_req, int'(rst_req), int'(m_pulse != 0));
      chk(int'(tap_sel) == m_sel, "R10", int'(tap_sel), m_sel);
    end
    if (rst_req && !prev_req) pulses++;
    prev_req = rst_req;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_up();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic service(int gap);
    wr(1'b1, 8'hA5);
    idle(gap);
    wr(1'b1, 8'h5A);
  endtask

  initial begin
    int p0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk(rst_req == 1'b0, "R1", int'(rst_req), 0);
    chk(tap_sel == 2'd0, "R1", int'(tap_sel), 0);

    // R4: disabled watchdog never requests
    cur_req = "R4";
    p0 = pulses; idle(200);
    chk(pulses == p0, "R4", pulses - p0, 0);

    // R3/R10: fields load before enable, frozen after
    cur_req = "R3";
    wr(1'b0, 8'h02);
    chk(tap_sel == 2'd2, "R10", int'(tap_sel), 2);
    wr(1'b0, 8'h82);
    wr(1'b0, 8'h03);
    idle(1);
    chk(tap_sel == 2'd2, "R3", int'(tap_sel), 2);
    // R5: unserviced watchdog fires
    cur_req = "R5";
    p0 = pulses; idle(140);
    chk(pulses > p0, "R5", pulses - p0, 1);

    // R1: system reset drops enable
    sys_reset();
    cur_req = "R1";
    chk(tap_sel == 2'd0, "R1", int'(tap_sel), 0);
    p0 = pulses; idle(150);
    chk(pulses == p0, "R1", pulses - p0, 0);

    // R6: regular service keeps it quiet (tick bit TB+3)
    cur_req = "R6";
    wr(1'b0, 8'h83);
    p0 = pulses;
    for (int i = 0; i < 15; i++) begin service(2); idle(16); end
    chk(pulses == p0, "R6", pulses - p0, 0);

    // R6: broken sequence and lone 0x5A do not clear
    p0 = pulses;
    for (int i = 0; i < 8; i++) begin
      wr(1'b1, 8'hA5); wr(1'b1, 8'h33); wr(1'b1, 8'h5A); idle(12);
      wr(1'b1, 8'h5A); idle(12);
    end
    chk(pulses > p0, "R6", pulses - p0, 1);

    // R7: long gap inside the pair
    sys_reset();
    cur_req = "R7";
    wr(1'b0, 8'h83);
    p0 = pulses;
    for (int i = 0; i < 6; i++) service(55);
    chk(pulses == p0, "R7", pulses - p0, 0);

    // R9: each hold-off input defers the reset
    sys_reset();
    cur_req = "R9";
    wr(1'b0, 8'h80);
    for (int b = 0; b < 4; b++) begin
      holdoff = 4'(1 << b);
      p0 = pulses; idle(100);
      chk(pulses == p0, "R9", pulses - p0, 0);
      holdoff = 4'h0;
      wr(1'b1, 8'hA5); wr(1'b1, 8'h5A);
    end
    p0 = pulses; idle(60);
    chk(pulses > p0, "R9", pulses - p0, 1);

    // R8: completing write on the very edge that would fire
    sys_reset();
    cur_req = "R8";
    wr(1'b0, 8'h83);
    wr(1'b1, 8'hA5);
    for (int i = 0; i < 400; i++) begin
      if (m_act && m_flag && m_prev && tapbit(m_cnt, m_sel) == 0) break;
      @(negedge clk);
    end
    chk(m_flag == 1, "R8", m_flag, 1);
    p0 = pulses;
    wr(1'b1, 8'h5A);
    idle(60);
    chk(pulses == p0, "R8", pulses - p0, 0);

    // R2: half-rate divider, unserviced
    sys_reset();
    cur_req = "R2";
    wr(1'b0, 8'h84);
    p0 = pulses; idle(100);
    chk(pulses > p0, "R2", pulses - p0, 1);
    idle(10);
    finish_up();
  end
endmodule